// File: doc/BRIEF.md
# Column-Driven Butterfly Word Shuffler

This block sits between a memory controller's request logic and its DRAM data path. A cache line of `WORDS` words (eight 64-bit words by default) is reordered before it is written, and the same reordering is applied after the line is read back. The reordering comes from the low bits of the column address. Because of this, the words of any power-of-two strided pattern land on different DRAM chips. Each stage of the reordering is a butterfly stage. Stage k swaps blocks of 2^(k-1) words with their neighbouring block. A stage is active only when its column bit is set.

Every stage swap undoes itself, and the stages commute with one another. The read path therefore uses the same stage controls as the write path, and restoring a line needs no extra information. A per-structure enable turns the reordering off for data that does not need it. A stage mask can switch off individual stages. Each direction has its own valid/ready pipeline with one register stage per butterfly stage. Each pipeline accepts one line per clock and holds its contents under backpressure.

Top module: `stride_shuffler`

## Requirements
- R1: There are STAGES = log2(WORDS) stages. Column bit k (weight 2^k) drives stage k+1, which exchanges word i with word i XOR 2^k. The net effect is that output word i equals input word (i XOR ctrl), where word 0 is the least significant `WORD_W` bits of the line.
- R2: With only column bit 0 effective, each adjacent pair of words (2j, 2j+1) is exchanged.
- R3: With only column bit 1 effective, the two pairs inside each group of four words change places. With only bit 2 effective, the two halves of each group of eight words change places.
- R4: A column value of 0 passes the line through unchanged.
- R5: A line accepted on a path appears at that path's output exactly STAGES clock cycles later. This holds whether the reordering is enabled or not.
- R6: When the shuffle enable of a path is 0, the line passes through unchanged for every column value.
- R7: The effective control is column bits AND stage mask, and it is zero when the enable is low. For example, column 3 with mask 2 applies only the pair exchange.
- R8: The read path applies the same permutation as the write path. Feeding a shuffled line back through the read path with the same column, enable and mask returns the original line.
- R9: A path with a stalled output holds its output line and valid steady. It stores at most STAGES lines, lowers its input ready once full, and delivers all lines in order once the stall ends. With no stall it accepts one line per cycle.
- R10: The two paths are independent. A stall on one path does not delay or alter traffic on the other.
- R11: During and after reset, both output valids and are 0 and both input readies are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_in_valid | input | 1 | Write-path line offered |
| wr_in_ready | output | 1 | Write path can take a line |
| wr_in_line | input | WORDS*WORD_W | Line to shuffle |
| wr_col_lsb | input | STAGES | Low column-address bits for the write line |
| wr_shuf_en | input | 1 | Shuffle enable for the write line's structure |
| wr_stage_mask | input | STAGES | Per-stage enable mask for the write line |
| wr_out_valid | output | 1 | Shuffled line available |
| wr_out_ready | input | 1 | Downstream accepts the shuffled line |
| wr_out_line | output | WORDS*WORD_W | Shuffled line |
| rd_in_valid | input | 1 | Read-path line offered |
| rd_in_ready | output | 1 | Read path can take a line |
| rd_in_line | input | WORDS*WORD_W | Line to unshuffle |
| rd_col_lsb | input | STAGES | Low column-address bits for the read line |
| rd_shuf_en | input | 1 | Shuffle enable for the read line's structure |
| rd_stage_mask | input | STAGES | Per-stage enable mask for the read line |
| rd_out_valid | output | 1 | Restored line available |
| rd_out_ready | input | 1 | Downstream accepts the restored line |
| rd_out_line | output | WORDS*WORD_W | Restored line |

## Verification
Every word of a test line carries its own index and a tag, so a misplaced word shows up as a position error and not just a data error. All eight column values are sent with the full mask. Single-bit columns separate the word, pair and quad exchanges, and the combined columns show that the stages compose. Runs with the enable off and with a partial mask show that gating and masking act per stage while the latency stays the same. Round trips through both paths, a long stall with back-to-back input, and read traffic during a write stall separate inverse behaviour, flow control and path independence.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

    // Number of butterfly stages needed for a line of the given word count.
    function automatic int stage_count(input int words);
        return $clog2(words);
    endfunction

    // Word index that trades places with word idx at butterfly level lvl.
    function automatic int partner(input int idx, input int lvl);
        return idx ^ (1 << lvl);
    endfunction

endpackage

// File: rtl/shuf_stage.sv
module shuf_stage #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 64,
    parameter int STAGES = 3,
    parameter int LEVEL  = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [WORDS*WORD_W-1:0] in_data,
    input  logic [STAGES-1:0]       in_ctrl,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [WORDS*WORD_W-1:0] out_data,
    output logic [STAGES-1:0]       out_ctrl
);
    import shuf_pkg::*;

    localparam int LINE_W = WORDS * WORD_W;

    typedef struct packed {
        logic              valid;
        logic [STAGES-1:0] ctrl;
        logic [LINE_W-1:0] data;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.valid || out_ready;
        if (in_ready) begin
            st_d.valid = in_valid;
            if (in_valid) begin
                st_d.ctrl = in_ctrl;
                for (int i = 0; i < WORDS; i++) begin
                    if (in_ctrl[LEVEL])
                        st_d.data[i*WORD_W +: WORD_W] = in_data[partner(i, LEVEL)*WORD_W +: WORD_W];
                    else
                        st_d.data[i*WORD_W +: WORD_W] = in_data[i*WORD_W +: WORD_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
    assign out_ctrl  = st_q.ctrl;

    // XOR of all words, used to check that a stage only moves words around.
    logic [WORD_W-1:0] in_fold, out_fold;
    always_comb begin
        in_fold  = '0;
        out_fold = '0;
        for (int i = 0; i < WORDS; i++) begin
            in_fold  = in_fold  ^ in_data[i*WORD_W +: WORD_W];
            out_fold = out_fold ^ out_data[i*WORD_W +: WORD_W];
        end
    end

    // R1
    word_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && out_fold == $past(in_fold));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ctrl));

endmodule

// File: rtl/shuf_pipe.sv
module shuf_pipe #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 64,
    parameter int STAGES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [WORDS*WORD_W-1:0] in_line,
    input  logic [STAGES-1:0]       in_ctrl,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [WORDS*WORD_W-1:0] out_line
);
    localparam int LINE_W = WORDS * WORD_W;
    localparam int OCC_W  = $clog2(STAGES + 2);

    logic [STAGES:0]             vld_chain;
    logic [STAGES:0]             rdy_chain;
    logic [STAGES:0][LINE_W-1:0] dat_chain;
    logic [STAGES:0][STAGES-1:0] ctl_chain;

    assign vld_chain[0] = in_valid;
    assign dat_chain[0] = in_line;
    assign ctl_chain[0] = in_ctrl;
    assign in_ready     = rdy_chain[0];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        shuf_stage #(
            .WORDS (WORDS),
            .WORD_W(WORD_W),
            .STAGES(STAGES),
            .LEVEL (g)
        ) i_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (vld_chain[g]),
            .in_ready (rdy_chain[g]),
            .in_data  (dat_chain[g]),
            .in_ctrl  (ctl_chain[g]),
            .out_valid(vld_chain[g+1]),
            .out_ready(rdy_chain[g+1]),
            .out_data (dat_chain[g+1]),
            .out_ctrl (ctl_chain[g+1])
        );
    end

    assign rdy_chain[STAGES] = out_ready;
    assign out_valid         = vld_chain[STAGES];
    assign out_line          = dat_chain[STAGES];

    wire unused_last_ctrl = ^ctl_chain[STAGES];

    // Lines held inside the pipe, counted from the edge handshakes only.
    logic [OCC_W-1:0] occ_d, occ_q;
    always_comb begin
        occ_d = occ_q;
        if (in_valid && in_ready)    occ_d = occ_d + 1'b1;
        if (out_valid && out_ready)  occ_d = occ_d - 1'b1;
    end
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    // R9
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(STAGES));

    // R9
    valid_has_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> occ_q != '0);

endmodule

// File: rtl/stride_shuffler.sv
module stride_shuffler #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 64,
    parameter int STAGES = shuf_pkg::stage_count(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_in_valid,
    output logic                    wr_in_ready,
    input  logic [WORDS*WORD_W-1:0] wr_in_line,
    input  logic [STAGES-1:0]       wr_col_lsb,
    input  logic                    wr_shuf_en,
    input  logic [STAGES-1:0]       wr_stage_mask,
    output logic                    wr_out_valid,
    input  logic                    wr_out_ready,
    output logic [WORDS*WORD_W-1:0] wr_out_line,
    input  logic                    rd_in_valid,
    output logic                    rd_in_ready,
    input  logic [WORDS*WORD_W-1:0] rd_in_line,
    input  logic [STAGES-1:0]       rd_col_lsb,
    input  logic                    rd_shuf_en,
    input  logic [STAGES-1:0]       rd_stage_mask,
    output logic                    rd_out_valid,
    input  logic                    rd_out_ready,
    output logic [WORDS*WORD_W-1:0] rd_out_line
);
    logic [STAGES-1:0] wr_ctrl, rd_ctrl;

    assign wr_ctrl = wr_col_lsb & wr_stage_mask & {STAGES{wr_shuf_en}};
    assign rd_ctrl = rd_col_lsb & rd_stage_mask & {STAGES{rd_shuf_en}};

    shuf_pipe #(.WORDS(WORDS), .WORD_W(WORD_W), .STAGES(STAGES)) i_wr_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (wr_in_valid),
        .in_ready (wr_in_ready),
        .in_line  (wr_in_line),
        .in_ctrl  (wr_ctrl),
        .out_valid(wr_out_valid),
        .out_ready(wr_out_ready),
        .out_line (wr_out_line)
    );

    shuf_pipe #(.WORDS(WORDS), .WORD_W(WORD_W), .STAGES(STAGES)) i_rd_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rd_in_valid),
        .in_ready (rd_in_ready),
        .in_line  (rd_in_line),
        .in_ctrl  (rd_ctrl),
        .out_valid(rd_out_valid),
        .out_ready(rd_out_ready),
        .out_line (rd_out_line)
    );

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !wr_out_valid && !rd_out_valid);

endmodule

// File: tb/test_stride_shuffler.sv
module test_stride_shuffler;
    localparam int WORDS  = 8;
    localparam int WORD_W = 64;
    localparam int S      = 3;
    localparam int LW     = WORDS * WORD_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          wr_in_valid = 0, wr_shuf_en = 0, wr_out_ready = 1;
    logic          rd_in_valid = 0, rd_shuf_en = 0, rd_out_ready = 1;
    logic [LW-1:0] wr_in_line = '0, rd_in_line = '0;
    logic [S-1:0]  wr_col_lsb = '0, wr_stage_mask = '0, rd_col_lsb = '0, rd_stage_mask = '0;
    logic          wr_in_ready, wr_out_valid, rd_in_ready, rd_out_valid;
    logic [LW-1:0] wr_out_line, rd_out_line;

    stride_shuffler #(.WORDS(WORDS), .WORD_W(WORD_W)) i_stride_shuffler (
        .clk, .rst_n,
        .wr_in_valid, .wr_in_ready, .wr_in_line, .wr_col_lsb, .wr_shuf_en, .wr_stage_mask,
        .wr_out_valid, .wr_out_ready, .wr_out_line,
        .rd_in_valid, .rd_in_ready, .rd_in_line, .rd_col_lsb, .rd_shuf_en, .rd_stage_mask,
        .rd_out_valid, .rd_out_ready, .rd_out_line
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [LW-1:0] got, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [LW-1:0] mk_line(input int tag);
        logic [LW-1:0] l;
        for (int i = 0; i < WORDS; i++)
            l[i*WORD_W +: WORD_W] = {32'(tag) ^ 32'hC0DE0000, 32'(i) ^ 32'h00A50000};
        return l;
    endfunction

    // Requirement-level model: output word i is input word (i XOR ctrl).
    function automatic logic [LW-1:0] permute(input logic [LW-1:0] l, input logic [S-1:0] c);
        logic [LW-1:0] r;
        for (int i = 0; i < WORDS; i++)
            r[i*WORD_W +: WORD_W] = l[(i ^ int'(c))*WORD_W +: WORD_W];
        return r;
    endfunction

    // One line through one path with an idle pipe; checks exact latency.
    task automatic xfer(input bit rd, input logic [LW-1:0] line, input logic [S-1:0] col,
                        input bit en, input logic [S-1:0] mask, input string req,
                        output logic [LW-1:0] got);
        @(negedge clk);
        if (rd) begin
            rd_in_valid = 1; rd_in_line = line; rd_col_lsb = col; rd_shuf_en = en; rd_stage_mask = mask;
        end else begin
            wr_in_valid = 1; wr_in_line = line; wr_col_lsb = col; wr_shuf_en = en; wr_stage_mask = mask;
        end
        @(negedge clk);
        rd_in_valid = 0;
        wr_in_valid = 0;
        for (int k = 1; k < S; k++) begin
            // R5: not yet at the output
            chk(!(rd ? rd_out_valid : wr_out_valid), {req, " R5 early valid"}, '0, '0);
            @(negedge clk);
        end
        chk(rd ? rd_out_valid : wr_out_valid, {req, " R5 valid at latency"}, '0, '1);
        got = rd ? rd_out_line : wr_out_line;
        @(negedge clk);
    endtask

    task automatic t_reset;
        // R11
        chk(!wr_out_valid, "R11 wr_out_valid", LW'(wr_out_valid), '0);
        chk(!rd_out_valid, "R11 rd_out_valid", LW'(rd_out_valid), '0);
        chk(wr_in_ready, "R11 wr_in_ready", LW'(wr_in_ready), '1);
        chk(rd_in_ready, "R11 rd_in_ready", LW'(rd_in_ready), '1);
    endtask

    task automatic t_all_columns;
        logic [LW-1:0] got, l;
        for (int c = 0; c < 8; c++) begin
            l = mk_line(16 + c);
            xfer(0, l, S'(c), 1, '1, "R1", got);
            // R1 R2 R3 R4: column c with full mask; c=0 identity, c=1 pairs, c=2 quads, c=4 halves
            chk(got == permute(l, S'(c)),
                c == 0 ? "R4 identity" : c == 1 ? "R2 pair swap" : (c == 2 || c == 4) ? "R3 block swap" : "R1 composed",
                got, permute(l, S'(c)));
        end
    endtask

    task automatic t_disabled;
        logic [LW-1:0] got, l;
        for (int c = 1; c < 8; c += 3) begin
            l = mk_line(40 + c);
            xfer(0, l, S'(c), 0, '1, "R6", got);
            chk(got == l, "R6 enable low passes line", got, l);
        end
        l = mk_line(50);
        xfer(1, l, 3'd7, 0, '1, "R6", got);
        chk(got == l, "R6 read path enable low", got, l);
    endtask

    task automatic t_mask;
        logic [LW-1:0] got, l;
        l = mk_line(60);
        xfer(0, l, 3'd3, 1, 3'b010, "R7", got);
        chk(got == permute(l, 3'd2), "R7 col3 mask2 pair only", got, permute(l, 3'd2));
        l = mk_line(61);
        xfer(1, l, 3'd7, 1, 3'b101, "R7", got);
        chk(got == permute(l, 3'd5), "R7 col7 mask5", got, permute(l, 3'd5));
        l = mk_line(62);
        xfer(0, l, 3'd6, 1, 3'b001, "R7", got);
        chk(got == l, "R7 mask removes all active bits", got, l);
    endtask

    task automatic t_roundtrip;
        logic [LW-1:0] mid, back, l;
        for (int c = 0; c < 8; c++) begin
            l = mk_line(80 + c);
            xfer(0, l, S'(c), 1, '1, "R8", mid);
            xfer(1, mid, S'(c), 1, '1, "R8", back);
            chk(back == l, "R8 read restores write", back, l);
        end
    endtask

    task automatic t_backpressure;
        logic [LW-1:0] lines [5];
        logic [LW-1:0] held;
        int sent = 0;
        int recv = 0;
        for (int n = 0; n < 5; n++) lines[n] = mk_line(100 + n);
        wr_out_ready = 0;
        wr_col_lsb = 3'd5; wr_shuf_en = 1; wr_stage_mask = '1;
        for (int cyc = 0; cyc < 30; cyc++) begin
            @(negedge clk);
            if (cyc == 5) held = wr_out_line;
            if (cyc == 8) begin
                // R9: full at STAGES lines, head held steady
                chk(sent == S, "R9 stored line count", LW'(sent), LW'(S));
                chk(!wr_in_ready, "R9 ready low when full", LW'(wr_in_ready), '0);
                chk(wr_out_valid && wr_out_line == held && held == permute(lines[0], 3'd5),
                    "R9 head held under stall", wr_out_line, permute(lines[0], 3'd5));
                wr_out_ready = 1;
            end
            if (wr_out_valid && wr_out_ready && recv < 5) begin
                chk(wr_out_line == permute(lines[recv], 3'd5), "R9 in-order delivery",
                    wr_out_line, permute(lines[recv], 3'd5));
                recv++;
            end
            if (sent < 5) begin
                wr_in_valid = 1; wr_in_line = lines[sent];
                #1;
                if (wr_in_ready) sent++;
            end else begin
                wr_in_valid = 0;
            end
        end
        chk(recv == 5, "R9 all lines delivered", LW'(recv), LW'(5));
    endtask

    task automatic t_independent;
        logic [LW-1:0] got, lw, lr;
        lw = mk_line(120);
        lr = mk_line(121);
        wr_out_ready = 0;
        @(negedge clk);
        wr_in_valid = 1; wr_in_line = lw; wr_col_lsb = 3'd1; wr_shuf_en = 1; wr_stage_mask = '1;
        @(negedge clk);
        wr_in_valid = 0;
        xfer(1, lr, 3'd6, 1, '1, "R10", got);
        chk(got == permute(lr, 3'd6), "R10 read path during write stall", got, permute(lr, 3'd6));
        chk(wr_out_valid && wr_out_line == permute(lw, 3'd1), "R10 stalled write line intact",
            wr_out_line, permute(lw, 3'd1));
        wr_out_ready = 1;
        @(negedge clk);
        chk(!wr_out_valid, "R10 write drained", LW'(wr_out_valid), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_all_columns();
        t_disabled();
        t_mask();
        t_roundtrip();
        t_backpressure();
        t_independent();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule